// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It runs on the system clock and advances only on a clock enable that pulses at sixteen times the bit rate. A falling edge on the idle-high line starts a candidate frame. The frame is confirmed half a bit later. After that, each data, parity and stop bit is sampled near its centre.

A completed character passes from the shift stage into a holding register. The host reads it from there, so one character can be assembled while the previous one waits. Each held character carries parity, framing and break flags. An overrun flag reports a character that was lost because the holding register was still full. A loopback select takes the serial data from the local transmitter output instead of the external pin. The format inputs set the word length and the parity. They should only change while the line is idle.

Top module: `async_rx`

## Requirements
- R1: `wlen_i` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first and appear right-aligned on `data_o`, with the unused upper bits at zero.
- R2: The line is sampled on each `tick_i`. A low sample while idle opens a start bit. That start bit is checked again 8 ticks later. If the line is high then, the event is dropped and no character is produced.
- R3: After a confirmed start, each following bit is sampled once every 16 ticks, counted from the start-bit check.
- R4: When `par_en_i` is 1, one parity bit follows the data. `par_even_i` = 1 selects even parity and 0 selects odd parity. `perr_o` is set for the character when the count of ones in the data plus the parity bit does not match the selected parity.
- R5: `ferr_o` is set for the character when its stop bit samples low.
- R6: A frame whose start, data, parity and stop samples are all low is reported as a character of value 0 with both `brk_o` and `ferr_o` set. The receiver then waits for the line to go high before it accepts a new start bit.
- R7: When a character is transferred, `dready_o` rises in the clock cycle after the stop-bit sample. It falls in the cycle after a clock with `rd_i` high.
- R8: If a character completes while `dready_o` is 1 and `rd_i` is 0, the held character and its flags are kept, the new character is discarded and `oerr_o` is set.
- R9: With `lb_sel_i` = 1, the receiver takes its input from `lb_txd_i`, and `rxd_i` has no effect.
- R10: During reset, `data_o` and all flag outputs are 0.
- R11: A clock with `rd_i` high clears `dready_o`, `perr_o`, `ferr_o`, `brk_o` and `oerr_o`. `data_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock enable at 16 times the bit rate |
| rxd_i | input | 1 | External serial input, idle high |
| lb_txd_i | input | 1 | Local transmitter output, used in loopback |
| lb_sel_i | input | 1 | 1 selects loopback input |
| wlen_i | input | 2 | Word length code (5 + value bits) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | 1 for even parity, 0 for odd parity |
| rd_i | input | 1 | Host read strobe, one clock |
| data_o | output | 8 | Held character |
| dready_o | output | 1 | Holding register has an unread character |
| perr_o | output | 1 | Parity error of held character |
| ferr_o | output | 1 | Framing error of held character |
| brk_o | output | 1 | Held character was a break |
| oerr_o | output | 1 | A character was lost to overrun |

## Verification
The input passes through a two-flop synchronizer. A tick that confirms a start therefore falls between half a tick and one and a half ticks past the bench's falling edge, plus eight ticks. A character lands in the holding register one clock after the stop sample, which is about nine and a half bit-ticks into the stop bit. The bench drives each bit for a whole bit time and leaves one idle bit after every frame. The monitor polls `dready_o` on falling clock edges and compares the character against the queue as soon as it appears. It then checks that `dready_o` has dropped exactly one clock after its read pulse. Checks that nothing was produced, after a glitch or during a held break, are made several bit times after the stimulus, so any late character would already be visible.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } rx_flags_t;
endpackage

// File: rtl/async_rx_front.sv
module async_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  input  logic lb_txd_i,
  input  logic lb_sel_i,
  output logic line_o
);
  logic raw;
  assign raw = lb_sel_i ? lb_txd_i : rxd_i;

  generate
    if (SYNC_STAGES < 2) begin : g_one
      logic sq;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= 1'b1;
        else         sq <= raw;
      assign line_o = sq;
    end else begin : g_many
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '1;
        else         sq <= {sq[SYNC_STAGES-2:0], raw};
      assign line_o = sq[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/async_rx_deser.sv
module async_rx_deser
  import async_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int MIN_W  = 5,
  parameter int MAX_W  = 8,
  parameter int WLEN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              done_o,
  output logic [MAX_W-1:0]  data_o,
  output rx_flags_t         flags_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [MAX_W-1:0] shreg;
  logic             all_low, par_acc, perr_q;

  assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(wlen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      all_low <= 1'b0;
      par_acc <= 1'b0;
      perr_q  <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      flags_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state)
          ST_IDLE: if (!line_i) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: begin
            if (cnt == MID) begin
              cnt     <= '0;
              idx     <= '0;
              shreg   <= '0;
              all_low <= 1'b1;
              par_acc <= 1'b0;
              perr_q  <= 1'b0;
              state   <= line_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt        <= '0;
              shreg[idx] <= line_i;
              all_low    <= all_low & ~line_i;
              par_acc    <= par_acc ^ line_i;
              if (idx == last_idx) state <= par_en_i ? ST_PAR : ST_STOP;
              else                 idx   <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == LAST) begin
              cnt     <= '0;
              all_low <= all_low & ~line_i;
              perr_q  <= par_acc ^ line_i ^ ~par_even_i;
              state   <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt          <= '0;
              done_o       <= 1'b1;
              data_o       <= shreg;
              flags_o.perr <= perr_q;
              flags_o.ferr <= ~line_i;
              flags_o.brk  <= all_low & ~line_i;
              state        <= (all_low & ~line_i) ? ST_BRKWAIT : ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_BRKWAIT: if (line_i) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
  import async_rx_pkg::*;
#(
  parameter int MAX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] ldata_i,
  input  rx_flags_t        lflags_i,
  input  logic             rd_i,
  output logic [MAX_W-1:0] data_o,
  output logic             dready_o,
  output rx_flags_t        flags_o,
  output logic             oerr_o
);
  logic still_full;
  assign still_full = dready_o & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      dready_o <= 1'b0;
      flags_o  <= '0;
      oerr_o   <= 1'b0;
    end else if (load_i && still_full) begin
      oerr_o <= 1'b1;  // new char dropped, old one kept
    end else if (load_i) begin
      data_o   <= ldata_i;
      flags_o  <= lflags_i;
      dready_o <= 1'b1;
      oerr_o   <= 1'b0;
    end else if (rd_i) begin
      dready_o <= 1'b0;
      flags_o  <= '0;
      oerr_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int MIN_W       = 5,
  parameter int MAX_W       = 8,
  parameter int WLEN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              lb_txd_i,
  input  logic              lb_sel_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              rd_i,
  output logic [MAX_W-1:0]  data_o,
  output logic              dready_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              oerr_o
);
  logic             line;
  logic             load;
  logic [MAX_W-1:0] ldata;
  rx_flags_t        lflags, hflags;

  async_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i, .rst_ni, .rxd_i, .lb_txd_i, .lb_sel_i, .line_o(line)
  );

  async_rx_deser #(.OSR(OSR), .MIN_W(MIN_W), .MAX_W(MAX_W), .WLEN_W(WLEN_W)) u_deser (
    .clk_i, .rst_ni, .tick_i, .line_i(line), .wlen_i, .par_en_i, .par_even_i,
    .done_o(load), .data_o(ldata), .flags_o(lflags)
  );

  async_rx_hold #(.MAX_W(MAX_W)) u_hold (
    .clk_i, .rst_ni, .load_i(load), .ldata_i(ldata), .lflags_i(lflags), .rd_i,
    .data_o, .dready_o, .flags_o(hflags), .oerr_o
  );

  assign perr_o = hflags.perr;
  assign ferr_o = hflags.ferr;
  assign brk_o  = hflags.brk;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int MAX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             load,
  input logic [MAX_W-1:0] ldata,
  input logic [MAX_W-1:0] data_o,
  input logic             dready_o,
  input logic             ferr_o,
  input logic             brk_o,
  input logic             oerr_o
);
  assert_overrun_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && dready_o && !rd_i |=> oerr_o && dready_o && $stable(data_o));

  assert_transfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && !(dready_o && !rd_i) |=> dready_o && data_o == $past(ldata));

  assert_read_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !load |=> !dready_o && !oerr_o && !ferr_o && !brk_o);

  assert_break_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> ferr_o && data_o == '0);

  assert_ready_from_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dready_o) |-> $past(load));
endmodule

bind async_rx async_rx_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i, .rst_ni, .rd_i, .load, .ldata, .data_o, .dready_o, .ferr_o, .brk_o, .oerr_o
);

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int TDIV = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0, tick = 0, rxd = 1, lb_txd = 1, lb_sel = 0;
  logic [1:0] wlen = 2'd3;
  logic par_en = 0, par_even = 0, mon_rd = 0, man_rd = 0, rd;
  logic [7:0] data;
  logic dready, perr, ferr, brk, oerr;
  assign rd = mon_rd | man_rd;

  async_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .lb_txd_i(lb_txd),
    .lb_sel_i(lb_sel), .wlen_i(wlen), .par_en_i(par_en), .par_even_i(par_even),
    .rd_i(rd), .data_o(data), .dready_o(dready), .perr_o(perr), .ferr_o(ferr),
    .brk_o(brk), .oerr_o(oerr)
  );

  typedef struct { logic [7:0] d; logic pe; logic fe; logic bk; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit auto_rd = 1, finished = 0;

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        tick = (i == 0);
      end
    end
  end

  task automatic put(bit to_lb, bit v);
    if (to_lb) lb_txd = v; else rxd = v;
  endtask

  task automatic hold(int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send(bit to_lb, logic [7:0] d, int nb, int pmode, bit badpar, bit stopv, bit push);
    logic [7:0] m;
    logic p;
    exp_t e;
    m = 8'((9'd1 << nb) - 1);
    if (push) begin
      e.d = d & m; e.pe = badpar; e.fe = !stopv; e.bk = 0;
      q.push_back(e);
    end
    put(to_lb, 0); hold(1);
    for (int i = 0; i < nb; i++) begin put(to_lb, d[i]); hold(1); end
    if (pmode != 0) begin
      p = ^(d & m);
      if (pmode == 2) p = ~p;
      if (badpar) p = ~p;
      put(to_lb, p); hold(1);
    end
    put(to_lb, stopv); hold(1);
    put(to_lb, 1); hold(1);
  endtask

  // monitor: pop and compare on each new character
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && auto_rd && dready) begin
        if (q.size() == 0) check(0, "R7 unexpected character", int'(data), 0);
        else begin
          e = q.pop_front();
          check(data == e.d, "R1 R3 data", int'(data), int'(e.d));
          check(perr == e.pe, "R4 parity flag", int'(perr), int'(e.pe));
          check(ferr == e.fe, "R5 framing flag", int'(ferr), int'(e.fe));
          check(brk == e.bk, "R6 break flag", int'(brk), int'(e.bk));
          check(oerr == 0, "R8 no overrun", int'(oerr), 0);
        end
        mon_rd = 1;
        @(negedge clk);
        mon_rd = 0;
        check(dready == 0, "R7 ready drops after read", int'(dready), 0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    exp_t e;
    repeat (5) @(negedge clk);
    check({data, dready, perr, ferr, brk, oerr} == '0, "R10 reset state",
          int'({data, dready, perr, ferr, brk, oerr}), 0);
    rst_n = 1;
    hold(2);

    // R1 R3: 8 data bits, no parity
    send(0, 8'hA5, 8, 0, 0, 1, 1);
    send(0, 8'h3C, 8, 0, 0, 1, 1);
    // R1: 5 data bits, upper bits dropped
    wlen = 2'd0;
    send(0, 8'hF3, 5, 0, 0, 1, 1);
    // R4: 6 bits even, 7 bits odd, 7 bits odd with wrong parity
    wlen = 2'd1; par_en = 1; par_even = 1;
    send(0, 8'h2D, 6, 1, 0, 1, 1);
    wlen = 2'd2; par_even = 0;
    send(0, 8'h55, 7, 2, 0, 1, 1);
    send(0, 8'h6B, 7, 2, 1, 1, 1);
    // R5: stop bit low
    wlen = 2'd3; par_en = 0;
    send(0, 8'h81, 8, 0, 0, 0, 1);
    hold(1);

    // R2: short low pulse is rejected
    rxd = 0; repeat (3 * TDIV) @(negedge clk); rxd = 1;
    hold(3);
    check(dready == 0 && q.size() == 0, "R2 glitch ignored", int'(dready), 0);

    // R6: break, line held low well past one frame
    e.d = 0; e.pe = 0; e.fe = 1; e.bk = 1;
    q.push_back(e);
    rxd = 0; hold(16);
    check(dready == 0 && q.size() == 0, "R6 single break character", int'(q.size()), 0);
    rxd = 1; hold(1);
    send(0, 8'h5A, 8, 0, 0, 1, 1);

    // R9: loopback source, external pin held low
    lb_sel = 1; rxd = 0;
    send(1, 8'h96, 8, 0, 0, 1, 1);
    rxd = 1; hold(1); lb_sel = 0;
    hold(1);

    // R8 R11: overrun keeps old character
    auto_rd = 0;
    send(0, 8'h11, 8, 0, 0, 1, 0);
    send(0, 8'h22, 8, 0, 0, 1, 0);
    hold(1);
    check(data == 8'h11, "R8 old character kept", int'(data), 8'h11);
    check(oerr == 1, "R8 overrun flag", int'(oerr), 1);
    check(dready == 1, "R8 still ready", int'(dready), 1);
    man_rd = 1; @(negedge clk); man_rd = 0;
    check(dready == 0 && oerr == 0, "R11 read clears flags", int'({dready, oerr}), 0);
    check(data == 8'h11, "R11 data kept after read", int'(data), 8'h11);
    auto_rd = 1;

    hold(2);
    check(q.size() == 0, "R7 all characters delivered", q.size(), 0);
    finish_run();
  end
endmodule